// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters with no tags. The table is addressed by a few bits of the branch program counter. A fetch-side lookup port gives a direction in the same cycle as the program counter is presented. A resolve-side update port moves the addressed counter one step toward the real outcome. Branches whose addresses fold onto the same entry share a single counter, and each one disturbs the other.

A branch's history leaks through aliased entries. To stop that leak between privilege contexts, the table is swept back to a neutral value each time the core enters supervisor mode from user mode. The same sweep runs after reset. The sweep writes one entry per clock and raises a busy flag while it runs. During the sweep, updates are dropped and every lookup answers not-taken.

Top module: `bimodal_predictor`

## Requirements
- R1: Each entry is a 2-bit counter: 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken, 2'b11 strongly taken.
- R2: `pred_taken` is high in the same cycle exactly when the entry addressed by `look_pc` holds 2'b10 or 2'b11, provided `busy` is low.
- R3: An update with `upd_valid` high and `upd_taken` high raises the addressed counter by one, and it stays at 2'b11 once there. So a strong not-taken miss goes to weak, and a weak correct hit goes to strong.
- R4: An update with `upd_taken` low lowers the addressed counter by one, and it stays at 2'b00 once there.
- R5: The entry index is `pc[4 +: log2(DEPTH)]`, which is (pc >> 4) modulo DEPTH. Program counters with equal index bits share one counter, and the higher and lower bits are ignored.
- R6: After synchronous reset (`rst_n` low at a clock edge), `busy` stays high for exactly DEPTH cycles once reset is released. After that, every entry holds 2'b01.
- R7: A rise of `priv_super` from 0 to 1 restarts the sweep from entry 0. `busy` is high for DEPTH cycles, and then every entry holds 2'b01. A fall of `priv_super` has no effect.
- R8: While `busy` is high, updates change no entry and `pred_taken` is low.
- R9: When a lookup and an update address the same entry in one cycle, the lookup returns the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a sweep |
| look_pc | input | PC_W | Program counter of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Strobe for a resolved branch |
| upd_pc | input | PC_W | Program counter of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| priv_super | input | 1 | Current privilege level, 1 = supervisor |
| busy | output | 1 | High while the table is being swept |

## Verification
A corrupted counter shows up at `pred_taken` on the first lookup of that index after the faulty write, which is the cycle after the bad update. A counter that saturates wrongly needs one or two further updates before the prediction bit shows the fault. A fault in the sweep sequencer changes the cycle in which `busy` falls. Entries left unswept show up as stale taken predictions on later lookups. For this reason, counters are driven to taken states before each sweep. An update that slips through during a sweep shows on the first lookup of that entry once `busy` is low.

// File: rtl/bp_pkg.sv
// Package: shared counter encoding for the bimodal predictor.
// Assumes nothing; bit 1 of a counter is its predicted direction.
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    localparam ctr_t CTR_NEUTRAL = CTR_WNT;
endpackage

// File: rtl/bp_index_hash.sv
// Module: bp_index_hash
// Maps a program counter to a table index by taking bits [4 +: IDX_W].
// Assumes PC_W >= IDX_W + 4 and that instructions are 16-byte grouped.
module bp_index_hash #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int SHIFT = 4;

    // Select the index field above the fetch-group offset.
    always_comb idx = pc[SHIFT +: IDX_W];

    initial begin
        a_r5_pc_wide_enough: assert (PC_W >= IDX_W + SHIFT)
            else $error("PC_W too narrow for the index");
    end
endmodule

// File: rtl/bp_sat_step.sv
// Module: bp_sat_step
// Next value of a 2-bit saturating counter given the resolved outcome.
// Assumes the counter encoding of bp_pkg (ordered SNT..ST).
module bp_sat_step
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Step toward the outcome, holding at either end.
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
    end
endmodule

// File: rtl/bp_flush_seq.sv
// Module: bp_flush_seq
// Sweep sequencer: on reset or on a user-to-supervisor rise it walks an
// index from 0 to DEPTH-1, one step per clock, with busy high throughout.
// Assumes DEPTH is a power of two and the rise is seen at a clock edge.
module bp_flush_seq #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             priv_super,
    output logic             busy,
    output logic [IDX_W-1:0] sweep_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic priv_q;
    logic start;
    logic at_last;

    // Detect entry into supervisor mode.
    always_comb start = priv_super & ~priv_q;
    always_comb at_last = (sweep_idx == LAST);

    // Remember the previous privilege level.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_q <= priv_super;
        else        priv_q <= priv_super;
    end

    // Advance the sweep; a new rise restarts it from entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b1;
            sweep_idx <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            sweep_idx <= '0;
        end else if (busy) begin
            busy      <= ~at_last;
            sweep_idx <= at_last ? '0 : sweep_idx + 1'b1;
        end
    end

    a_r6_sweep_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last) |=> busy);
    a_r6_sweep_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && at_last && !start) |=> !busy);
    a_r7_rise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && sweep_idx == '0));
    a_r7_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/bimodal_predictor.sv
// Module: bimodal_predictor
// Untagged table of 2-bit saturating counters. The lookup is combinational.
// Updates are written at the clock edge. A sweep clears the table after
// reset and on each entry to supervisor mode.
// Assumes DEPTH is a power of two and PC_W >= log2(DEPTH) + 4.
module bimodal_predictor
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] look_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            priv_super,
    output logic            busy
);
    localparam int IDX_W = $clog2(DEPTH);

    ctr_t             table_q [DEPTH];
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [IDX_W-1:0] sweep_idx;
    ctr_t             upd_cur;
    ctr_t             upd_next;

    bp_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_look_hash (
        .pc (look_pc),
        .idx(look_idx)
    );

    bp_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_hash (
        .pc (upd_pc),
        .idx(upd_idx)
    );

    bp_flush_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_super(priv_super),
        .busy      (busy),
        .sweep_idx (sweep_idx)
    );

    // Read the counter being trained.
    always_comb upd_cur = table_q[upd_idx];

    bp_sat_step u_step (
        .cur  (upd_cur),
        .taken(upd_taken),
        .nxt  (upd_next)
    );

    // Predict from the direction bit; suppressed during a sweep.
    always_comb pred_taken = ~busy & table_q[look_idx][1];

    // Write either the sweep value or a trained counter.
    always_ff @(posedge clk) begin
        if (busy)           table_q[sweep_idx] <= CTR_NEUTRAL;
        else if (upd_valid) table_q[upd_idx]   <= upd_next;
    end

    a_r3_hold_strong_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_valid && upd_taken && upd_cur == CTR_ST)
        |=> table_q[$past(upd_idx)] == CTR_ST);
    a_r4_hold_strong_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_valid && !upd_taken && upd_cur == CTR_SNT)
        |=> table_q[$past(upd_idx)] == CTR_SNT);
    a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pred_taken);
endmodule

// File: tb/sim_bimodal_predictor.sv
module sim_bimodal_predictor;
    localparam int PC_W  = 32;
    localparam int DEPTH = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] look_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            priv_super = 1'b0;
    logic            busy;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    logic [1:0] m_tbl [DEPTH];
    logic       m_busy = 1'b1;
    int         m_cnt = 0;
    logic       m_prev = 1'b0;

    always #2 clk = ~clk;

    bimodal_predictor #(.PC_W(PC_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .priv_super(priv_super), .busy(busy)
    );

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'((pc >> 4) & (DEPTH - 1));
    endfunction

    function automatic logic [1:0] sat(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Compare outputs, then pass one clock edge, then advance the model.
    task automatic cyc(string tag);
        #1;
        check(tag, busy, m_busy, "busy");
        check(tag, pred_taken, !m_busy && m_tbl[idx_of(look_pc)][1], "pred_taken");
        @(posedge clk);
        if (!rst_n) begin
            m_busy = 1'b1; m_cnt = 0;
        end else begin
            if (upd_valid && !m_busy)
                m_tbl[idx_of(upd_pc)] = sat(m_tbl[idx_of(upd_pc)], upd_taken);
            if (m_busy) begin
                m_tbl[m_cnt] = 2'b01;
                if (m_cnt == DEPTH - 1) begin m_busy = 1'b0; m_cnt = 0; end
                else m_cnt++;
            end
            if (priv_super && !m_prev) begin m_busy = 1'b1; m_cnt = 0; end
        end
        m_prev = priv_super;
        @(negedge clk);
    endtask

    task automatic upd(logic [PC_W-1:0] pc, logic t, string tag);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = t; look_pc = pc;
        cyc(tag);
        upd_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = 2'b11;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc("R6");
        rst_n = 1'b1;
        // R6 sweep after reset; R8 updates late in the sweep are dropped
        for (int i = 0; i < DEPTH; i++) begin
            if (i > DEPTH - 20) begin
                upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h0000_0030;
            end
            look_pc = 32'h0000_0030;
            cyc((i > DEPTH - 20) ? "R8" : "R6");
        end
        upd_valid = 1'b0;
        look_pc = 32'h0000_0030; cyc("R8");
        // R3 / R9: climb, saturate, then miss from strong taken
        upd(32'h0000_0070, 1'b1, "R9"); upd(32'h0000_0070, 1'b1, "R3");
        upd(32'h0000_0070, 1'b1, "R3"); upd(32'h0000_0070, 1'b0, "R3");
        look_pc = 32'h0000_0070; cyc("R3");
        upd(32'h0000_0070, 1'b0, "R3");
        look_pc = 32'h0000_0070; cyc("R1");
        // R4: fall to strong not-taken, then one taken outcome
        for (int i = 0; i < 3; i++) upd(32'h0000_0090, 1'b0, "R4");
        upd(32'h0000_0090, 1'b1, "R4");
        look_pc = 32'h0000_0090; cyc("R4");
        // R5: aliases share one counter
        upd(32'h0000_00A0, 1'b1, "R5");
        look_pc = 32'h0000_00A0 + DEPTH * 16 + 32'h7; cyc("R5");
        look_pc = 32'hF000_00AF; cyc("R5");
        // R7: load taken states, rise flushes, fall does nothing
        for (int i = 0; i < 8; i++) begin
            upd(32'(i * 16), 1'b1, "R7"); upd(32'(i * 16), 1'b1, "R7");
        end
        priv_super = 1'b1;
        look_pc = 32'h0000_0010;
        cyc("R7");
        while (m_busy) cyc("R7");
        for (int i = 0; i < 8; i++) begin look_pc = 32'(i * 16); cyc("R7"); end
        upd(32'h0000_0020, 1'b1, "R7");
        priv_super = 1'b0;
        for (int i = 0; i < 3; i++) begin look_pc = 32'h0000_0020; cyc("R7"); end
        // R2: random traffic with heavy aliasing and rare mode switches
        for (int i = 0; i < 5000; i++) begin
            logic [PC_W-1:0] p = ($urandom & 32'hFFFF_C00F) | (($urandom % 8) << 4);
            upd_valid = ($urandom % 3) != 0;
            upd_pc = p;
            upd_taken = ($urandom % 4) != 0;
            look_pc = ($urandom % 2) ? p : (($urandom & 32'hFFFF_C00F) | (($urandom % 8) << 4));
            if ($urandom % 400 == 0) priv_super = ~priv_super;
            cyc("R2");
        end
        upd_valid = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule